// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block moves data for a single channel that an external arbiter has already granted. When the channel is enabled, it captures two address/size/increment sets, an item count and the mode bits. One set describes the peripheral side and the other the memory side. A direction bit chooses which side is read. The engine then handles one item at a time. It reads the item from the source through a generic request/response memory port. It converts the item to the destination width and writes it to the destination.

Each item can wait for a hardware request from the peripheral, or it can start straight away in memory-to-memory mode. Addresses advance per side by that side's item size when increment is on. Circular mode reloads the addresses and the count when the block ends and keeps the channel running. Three sticky flags report progress and faults: half, complete and error. Their OR drives one interrupt line.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the channel is inactive, no memory request is driven and all flags are clear. A rising edge of `cfg_en_i` while inactive captures the configuration and makes `active_o` high on the next clock edge.
- R2: Each item is one read of the source followed by one write of the destination. `cfg_dir_i`=0 reads the peripheral side and writes the memory side. `cfg_dir_i`=1 does the reverse.
- R3: The size codes are 0 = byte, 1 = half-word and 2 = word. Data sits in the low bits of `mem_rdata_i`/`mem_wdata_i`. A narrow-to-wide item is zero-extended. A wide-to-narrow item keeps its least-significant bits.
- R4: A side with its increment bit set advances by its own item size in bytes (1, 2 or 4) after every completed item. A side with the bit clear keeps the same address.
- R5: A count of N transfers N items, and a count of 0 transfers 65536. After the N-th successful write the complete flag sets and, outside circular mode, `active_o` falls.
- R6: The half flag sets on the write that leaves floor(N/2) items remaining. For N=1 this is the final write.
- R7: In circular mode, completion reloads both start addresses and the count, and the channel stays active. The next read uses the start source address.
- R8: With memory-to-memory mode off, an item starts only while `periph_req_i` is high, and `periph_ack_o` pulses for one cycle on each completed write. With the mode on, items start without `periph_req_i`.
- R9: An error response on a read or a write sets the error flag, drops `active_o` and issues no further request. The failing write is not counted as an item.
- R10: Before a request is issued, its address is checked against its item size, and a size code of 3 is also treated as a fault. A failing check sets the error flag and stops the channel without issuing that access.
- R11: The flags stay set until `flag_clr_i`, which clears all three at once. `irq_o` is high exactly when any flag is set.
- R12: Once raised, `mem_req_o` stays high with the same address, size and write bit until the cycle in which `mem_rsp_valid_i` is high.
- R13: Driving `cfg_en_i` low lets the item in flight finish, then the channel goes inactive before it starts another item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Channel enable; rising edge starts |
| cfg_dir_i | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_m2m_i | input | 1 | Run items without hardware request |
| cfg_circ_i | input | 1 | Circular reload on completion |
| cfg_per_addr_i | input | ADDR_W | Peripheral-side start address |
| cfg_mem_addr_i | input | ADDR_W | Memory-side start address |
| cfg_per_size_i | input | 2 | Peripheral-side item size code |
| cfg_mem_size_i | input | 2 | Memory-side item size code |
| cfg_per_inc_i | input | 1 | Peripheral-side address increment |
| cfg_mem_inc_i | input | 1 | Memory-side address increment |
| cfg_count_i | input | CNT_W | Item count, 0 means 2**CNT_W |
| periph_req_i | input | 1 | Hardware request from the peripheral |
| periph_ack_o | output | 1 | Item done pulse to the peripheral |
| flag_clr_i | input | 1 | Clear all flags |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Access byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | DATA_W | Write data, low-aligned |
| mem_rsp_valid_i | input | 1 | Access completes this cycle |
| mem_rsp_err_i | input | 1 | Access failed |
| mem_rdata_i | input | DATA_W | Read data, low-aligned |
| active_o | output | 1 | Channel is running |
| ht_o | output | 1 | Half flag |
| tc_o | output | 1 | Complete flag |
| te_o | output | 1 | Error flag |
| irq_o | output | 1 | OR of the flags |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, 32-bit data and a 16-bit count. The 32-bit address width leaves room for an error region above the bench's 256-byte memory. The word data width covers every pairing of byte, half-word and word. With the 16-bit count, a count of 0 means 65536 items, and its half-way event at 32768 writes can be reached and counted within the run. The bench memory answers in the same cycle by default and can be stalled, so both the fast path and the held-request case appear.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_READ,
    ST_WRITE
  } eng_state_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // size code 3 is reserved and never aligned
  function automatic logic is_aligned(input logic [31:0] addr, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~addr[0];
      SZ_WORD: return ~|addr[1:0];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] init_i,
  input  logic [1:0]        size_i,
  input  logic              inc_i,
  input  logic              step_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic              aligned_o
);

  logic [ADDR_W-1:0] base_q, cur_q;
  logic [1:0]        size_q;
  logic              inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
      size_q <= SZ_BYTE;
      inc_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= init_i;
      cur_q  <= init_i;
      size_q <= size_i;
      inc_q  <= inc_i;
    end else if (reload_i) begin
      cur_q <= base_q;
    end else if (step_i && inc_q) begin
      cur_q <= cur_q + ADDR_W'(size_bytes(size_q));
    end
  end

  assign addr_o    = cur_q;
  assign size_o    = size_q;
  assign aligned_o = is_aligned(32'(cur_q), size_q);

  // R4
  fixed_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reload_i && !load_i && !inc_q) |=> $stable(cur_q));

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  input  logic             reload_i,
  output logic             last_o,
  output logic             half_hit_o
);

  localparam int TW = CNT_W + 1;
  localparam logic [TW-1:0] FULL = TW'(1) << CNT_W;

  logic [TW-1:0] total_q, remain_q, load_val;

  assign load_val = (count_i == '0) ? FULL : {1'b0, count_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q  <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      total_q  <= load_val;
      remain_q <= load_val;
    end else if (reload_i) begin
      remain_q <= total_q;
    end else if (dec_i) begin
      remain_q <= remain_q - TW'(1);
    end
  end

  assign last_o     = (remain_q == TW'(1));
  assign half_hit_o = ((remain_q - TW'(1)) == (total_q >> 1));

  // R5
  remain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_q <= total_q);

endmodule

// File: rtl/dma_size_conv.sv
module dma_size_conv
  import dma_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [1:0]        src_size_i,
  input  logic [1:0]        dst_size_i,
  output logic [DATA_W-1:0] dout_o
);

  localparam int NB = DATA_W / 8;

  logic [3:0] src_n, dst_n;
  assign src_n = size_bytes(src_size_i);
  assign dst_n = size_bytes(dst_size_i);

  // lane kept only if both source and destination carry it
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout_o[8*b +: 8] = (4'(b) < src_n && 4'(b) < dst_n) ? din_i[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_dir_i,
  input  logic              cfg_m2m_i,
  input  logic              cfg_circ_i,
  input  logic [ADDR_W-1:0] cfg_per_addr_i,
  input  logic [ADDR_W-1:0] cfg_mem_addr_i,
  input  logic [1:0]        cfg_per_size_i,
  input  logic [1:0]        cfg_mem_size_i,
  input  logic              cfg_per_inc_i,
  input  logic              cfg_mem_inc_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic              periph_req_i,
  output logic              periph_ack_o,
  input  logic              flag_clr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              active_o,
  output logic              ht_o,
  output logic              tc_o,
  output logic              te_o,
  output logic              irq_o
);

  eng_state_e state_q, state_d;
  logic en_q, dir_q, m2m_q, circ_q;
  logic ht_q, tc_q, te_q;
  logic [DATA_W-1:0] data_q, conv_data;

  logic start, load, step, dec, reload, cap;
  logic set_ht, set_tc, set_te;
  logic last, half_hit;

  // side 0: peripheral, side 1: memory
  logic [ADDR_W-1:0] side_addr [2];
  logic [1:0]        side_size [2];
  logic              side_ok   [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .init_i    ((s == 0) ? cfg_per_addr_i : cfg_mem_addr_i),
      .size_i    ((s == 0) ? cfg_per_size_i : cfg_mem_size_i),
      .inc_i     ((s == 0) ? cfg_per_inc_i  : cfg_mem_inc_i),
      .step_i    (step),
      .reload_i  (reload),
      .addr_o    (side_addr[s]),
      .size_o    (side_size[s]),
      .aligned_o (side_ok[s])
    );
  end

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [1:0]        src_size, dst_size;
  logic              src_ok, dst_ok;

  assign src_addr = side_addr[dir_q];
  assign dst_addr = side_addr[~dir_q];
  assign src_size = side_size[dir_q];
  assign dst_size = side_size[~dir_q];
  assign src_ok   = side_ok[dir_q];
  assign dst_ok   = side_ok[~dir_q];

  dma_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .count_i    (cfg_count_i),
    .dec_i      (dec),
    .reload_i   (reload),
    .last_o     (last),
    .half_hit_o (half_hit)
  );

  dma_size_conv #(.DATA_W(DATA_W)) u_conv (
    .din_i      (mem_rdata_i),
    .src_size_i (src_size),
    .dst_size_i (dst_size),
    .dout_o     (conv_data)
  );

  assign start = cfg_en_i && !en_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    dec     = 1'b0;
    reload  = 1'b0;
    cap     = 1'b0;
    set_ht  = 1'b0;
    set_tc  = 1'b0;
    set_te  = 1'b0;
    case (state_q)
      ST_OFF: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!cfg_en_i) begin
          state_d = ST_OFF;
        end else if (m2m_q || periph_req_i) begin
          if (!src_ok) begin
            set_te  = 1'b1;
            state_d = ST_OFF;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i || !dst_ok) begin
            set_te  = 1'b1;
            state_d = ST_OFF;
          end else begin
            cap     = 1'b1;
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) begin
            set_te  = 1'b1;
            state_d = ST_OFF;
          end else begin
            dec    = 1'b1;
            set_ht = half_hit;
            if (last) begin
              set_tc = 1'b1;
              if (circ_q) begin
                reload  = 1'b1;
                state_d = ST_WAIT;
              end else begin
                state_d = ST_OFF;
              end
            end else begin
              step    = 1'b1;
              state_d = ST_WAIT;
            end
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      m2m_q   <= 1'b0;
      circ_q  <= 1'b0;
      data_q  <= '0;
      ht_q    <= 1'b0;
      tc_q    <= 1'b0;
      te_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= cfg_en_i;
      if (load) begin
        dir_q  <= cfg_dir_i;
        m2m_q  <= cfg_m2m_i;
        circ_q <= cfg_circ_i;
      end
      if (cap) data_q <= conv_data;
      // set wins over clear
      ht_q <= set_ht | (ht_q & ~flag_clr_i);
      tc_q <= set_tc | (tc_q & ~flag_clr_i);
      te_q <= set_te | (te_q & ~flag_clr_i);
    end
  end

  assign mem_req_o    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o     = (state_q == ST_WRITE);
  assign mem_addr_o   = mem_we_o ? dst_addr : src_addr;
  assign mem_size_o   = mem_we_o ? dst_size : src_size;
  assign mem_wdata_o  = data_q;
  assign periph_ack_o = dec && !m2m_q;
  assign active_o     = (state_q != ST_OFF);
  assign ht_o         = ht_q;
  assign tc_o         = tc_q;
  assign te_o         = te_q;
  assign irq_o        = ht_q | tc_q | te_q;

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_size_o)));

  // R10
  req_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> is_aligned(32'(mem_addr_o), mem_size_o));

  // R9
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rsp_valid_i && mem_rsp_err_i) |=> (!mem_req_o && !active_o && te_o));

  // R8
  hw_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !m2m_q && !periph_req_i) |=> !mem_req_o);

  // R7
  circ_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_tc && circ_q) |=> (active_o && tc_o));

  // R11
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !set_ht && !set_tc && !set_te) |=> !irq_o);

endmodule

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        en = 0, dir = 0, m2m = 0, circ = 0;
  logic [31:0] pa = 0, ma = 0;
  logic [1:0]  ps = 0, ms = 0;
  logic        pinc = 0, minc = 0;
  logic [15:0] cnt = 0;
  logic        preq = 0, clr = 0, stall = 0;
  logic        ack, mreq, mwe, act, ht, tc, te, irq;
  logic [31:0] maddr, wdata, rdata;
  logic [1:0]  msz;
  logic        rvalid, rerr;

  dma_xfer_engine #(.ADDR_W(32), .DATA_W(32), .CNT_W(16)) i_dma_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_dir_i(dir), .cfg_m2m_i(m2m),
    .cfg_circ_i(circ), .cfg_per_addr_i(pa), .cfg_mem_addr_i(ma),
    .cfg_per_size_i(ps), .cfg_mem_size_i(ms), .cfg_per_inc_i(pinc), .cfg_mem_inc_i(minc),
    .cfg_count_i(cnt), .periph_req_i(preq), .periph_ack_o(ack), .flag_clr_i(clr),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_size_o(msz),
    .mem_wdata_o(wdata), .mem_rsp_valid_i(rvalid), .mem_rsp_err_i(rerr),
    .mem_rdata_i(rdata), .active_o(act), .ht_o(ht), .tc_o(tc), .te_o(te), .irq_o(irq)
  );

  function automatic logic [7:0] pat(input logic [7:0] i);
    return 8'(i * 8'd7 + 8'd3);
  endfunction

  function automatic logic [31:0] szmask(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // memory model: 256 bytes, anything above 0xFF answers with error
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic       init_req = 0;
  int         wr_cnt, req_cnt, ack_cnt;
  logic [7:0] a0, a1, a2, a3;

  always_comb begin
    a0 = maddr[7:0];
    a1 = 8'(maddr[7:0] + 8'd1);
    a2 = 8'(maddr[7:0] + 8'd2);
    a3 = 8'(maddr[7:0] + 8'd3);
    rdata  = {mem[a3], mem[a2], mem[a1], mem[a0]} & szmask(msz);
    rvalid = mreq && !stall;
    rerr   = mreq && (maddr[31:8] != 24'h0);
  end

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
      wr_cnt <= 0; req_cnt <= 0; ack_cnt <= 0;
    end else begin
      if (ack) ack_cnt <= ack_cnt + 1;
      if (rvalid) begin
        req_cnt <= req_cnt + 1;
        if (mwe && !rerr) begin
          wr_cnt <= wr_cnt + 1;
          mem[a0] <= wdata[7:0];
          if (msz >= 2'd1) mem[a1] <= wdata[15:8];
          if (msz == 2'd2) begin
            mem[a2] <= wdata[23:16];
            mem[a3] <= wdata[31:24];
          end
        end
      end
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic prep();
    @(negedge clk); en = 0; clr = 1; init_req = 1;
    @(negedge clk); clr = 0; init_req = 0;
  endtask

  task automatic go(input logic d, input logic mm, input logic cc, input logic [31:0] p,
                    input logic [31:0] m, input logic [1:0] psz, input logic [1:0] msz_,
                    input logic pi, input logic mi, input logic [15:0] n);
    prep();
    dir = d; m2m = mm; circ = cc; pa = p; ma = m; ps = psz; ms = msz_;
    pinc = pi; minc = mi; cnt = n; en = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && act; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic        dir;
    logic [1:0]  psz;
    logic [1:0]  msz;
    logic        pinc;
    logic        minc;
    logic [7:0]  pa;
    logic [7:0]  ma;
    logic [15:0] cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 8'h00, 8'h40, 16'd4},
    '{1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 8'h80, 8'h10, 16'd5},
    '{1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 8'h20, 8'h90, 16'd6},
    '{1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 8'h30, 8'hA0, 16'd3},
    '{1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 8'hC0, 8'h04, 16'd7},
    '{1'b0, 2'd1, 2'd0, 1'b1, 1'b1, 8'h08, 8'hD0, 16'd1}
  };

  task automatic build_exp(input vec_t t);
    logic [31:0] sb, db, sa, da, v;
    logic [1:0]  ss, ds;
    logic        si, di;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(8'(i));
    sb = t.dir ? {24'h0, t.ma} : {24'h0, t.pa};
    db = t.dir ? {24'h0, t.pa} : {24'h0, t.ma};
    ss = t.dir ? t.msz : t.psz;
    ds = t.dir ? t.psz : t.msz;
    si = t.dir ? t.minc : t.pinc;
    di = t.dir ? t.pinc : t.minc;
    for (int k = 0; k < int'(t.cnt); k++) begin
      sa = si ? sb + (32'(k) << ss) : sb;
      da = di ? db + (32'(k) << ds) : db;
      v = {pat(8'(sa + 3)), pat(8'(sa + 2)), pat(8'(sa + 1)), pat(sa[7:0])} & szmask(ss) & szmask(ds);
      exp_mem[da[7:0]] = v[7:0];
      if (ds >= 2'd1) exp_mem[8'(da + 1)] = v[15:8];
      if (ds == 2'd2) begin
        exp_mem[8'(da + 2)] = v[23:16];
        exp_mem[8'(da + 3)] = v[31:24];
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int bad, w;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 active after reset", act, 0);
    chk("R1 req after reset", mreq, 0);
    chk("R1 irq after reset", {ht, tc, te, irq}, 0);
    rst_n = 1;

    // table of width/direction/increment cases, memory-to-memory
    for (int v = 0; v < 6; v++) begin
      build_exp(VECS[v]);
      go(VECS[v].dir, 1'b1, 1'b0, {24'h0, VECS[v].pa}, {24'h0, VECS[v].ma},
         VECS[v].psz, VECS[v].msz, VECS[v].pinc, VECS[v].minc, VECS[v].cnt);
      chk("R1 active after enable", act, 1);
      wait_idle(200);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk("R2 R3 R4 memory image mismatches", bad, 0);
      chk("R5 item count", wr_cnt, {16'h0, VECS[v].cnt});
      chk("R5 complete flag", tc, 1);
      chk("R6 half flag", ht, 1);
      chk("R11 irq and no error", {irq, te}, 2'b10);
    end

    // R12: stalled memory keeps the request steady
    stall = 1;
    go(1'b0, 1'b1, 1'b0, 32'h24, 32'h60, 2'd2, 2'd2, 1'b1, 1'b1, 16'd1);
    repeat (5) @(negedge clk);
    chk("R12 request held", {mreq, mwe}, 2'b10);
    chk("R12 address held", maddr, 32'h24);
    stall = 0;
    wait_idle(20);
    chk("R12 completes after stall", wr_cnt, 1);

    // R8: hardware request gating and ack
    go(1'b0, 1'b0, 1'b0, 32'h00, 32'h40, 2'd0, 2'd0, 1'b1, 1'b1, 16'd3);
    repeat (10) @(negedge clk);
    chk("R8 no access without request", req_cnt, 0);
    preq = 1;
    wait_idle(50);
    preq = 0;
    chk("R8 items with request", wr_cnt, 3);
    chk("R8 ack pulses", ack_cnt, 3);

    // R6: half flag timing
    go(1'b0, 1'b1, 1'b0, 32'h00, 32'h40, 2'd0, 2'd0, 1'b1, 1'b1, 16'd4);
    for (int i = 0; i < 100 && !ht; i++) @(negedge clk);
    chk("R6 writes at half", wr_cnt, 2);
    chk("R6 not yet complete", tc, 0);
    wait_idle(50);

    // R7: circular reload
    go(1'b0, 1'b1, 1'b1, 32'h00, 32'h40, 2'd0, 2'd0, 1'b1, 1'b1, 16'd2);
    for (int i = 0; i < 100 && !tc; i++) @(negedge clk);
    chk("R7 still active after complete", act, 1);
    for (int i = 0; i < 20 && !(mreq && !mwe); i++) @(negedge clk);
    chk("R7 source reloaded", maddr, 32'h00);
    for (int i = 0; i < 20 && !(mreq && mwe); i++) @(negedge clk);
    chk("R7 destination reloaded", maddr, 32'h40);
    en = 0;
    wait_idle(20);
    chk("R13 stops after disable", act, 0);

    // R9: read error
    go(1'b0, 1'b1, 1'b0, 32'h100, 32'h40, 2'd0, 2'd0, 1'b1, 1'b1, 16'd2);
    wait_idle(20);
    chk("R9 read error flags", {te, tc, act}, 3'b100);
    chk("R9 single attempt", req_cnt, 1);
    chk("R11 irq on error", irq, 1);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    chk("R11 clear drops irq", {irq, te}, 0);

    // R9: write error
    go(1'b0, 1'b1, 1'b0, 32'h00, 32'h140, 2'd0, 2'd0, 1'b1, 1'b1, 16'd2);
    wait_idle(20);
    chk("R9 write error flags", {te, act}, 2'b10);
    chk("R9 no item counted", {req_cnt[15:0], wr_cnt[15:0]}, {16'd2, 16'd0});

    // R10: misaligned source, no access issued
    go(1'b0, 1'b1, 1'b0, 32'h01, 32'h40, 2'd1, 2'd1, 1'b1, 1'b1, 16'd2);
    wait_idle(20);
    chk("R10 misaligned source", {te, act}, 2'b10);
    chk("R10 no access", req_cnt, 0);

    // R10: misaligned destination, read only
    go(1'b0, 1'b1, 1'b0, 32'h00, 32'h42, 2'd2, 2'd2, 1'b1, 1'b1, 16'd2);
    wait_idle(20);
    chk("R10 misaligned destination", {te, act}, 2'b10);
    chk("R10 read only", {req_cnt[15:0], wr_cnt[15:0]}, {16'd1, 16'd0});

    // R5: count 0 means 65536, half flag after 32768 items; R13 disable mid-run
    go(1'b0, 1'b1, 1'b0, 32'h00, 32'h40, 2'd0, 2'd0, 1'b0, 1'b0, 16'd0);
    for (int i = 0; i < 120000 && !ht; i++) @(negedge clk);
    chk("R5 zero count half point", wr_cnt, 32768);
    chk("R5 not complete at half", tc, 0);
    w = wr_cnt;
    en = 0;
    wait_idle(10);
    chk("R13 inactive after disable", act, 0);
    chk("R13 at most one more item", 32'(wr_cnt - w <= 1), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule